// File: doc/BRIEF.md
# Bidirectional Volume Envelope Generator

This block produces the 4-bit volume level of a single sound channel. While enabled, it changes the level by one step at a fixed, programmable pace. The direction input sets whether the level rises or falls. When the level reaches the end of its range, it either stays there or jumps back to a programmed start value, as chosen by a repeat input. The level is meant to scale a channel's waveform elsewhere; that scaling and any channel shutoff are outside this block.

The step period is (interval + 1) times a base count. The base count is a parameter whose default, 307220, gives the slow envelope pace of the intended system. A restart strobe loads the start value into the level and starts a fresh, full step period. The interval, direction, repeat and start inputs are sampled live, in the cycle they are used.

Top module: `env_volume_gen`

## Requirements
- R1: Reset drives the 4-bit level output to 0.
- R2: With the direction input at 0 (down), each step lowers a nonzero level by 1.
- R3: With the direction input at 1 (up), each step raises a level below 15 by 1.
- R4: A step that finds the level at its end of range (0 when going down, 15 when going up) loads the start value if repeat is 1.
- R5: A step that finds the level at its end of range leaves the level unchanged if repeat is 0.
- R6: While enabled, steps are spaced exactly (interval + 1) × STEP_BASE clock cycles apart. The interval is read at the step that begins each period.
- R7: While the enable is 0 and no restart is given, both the level and the step timer hold. The remaining count resumes from where it stopped.
- R8: A restart loads the start value into the level on the next edge and begins a full step period. It works with the enable high or low, and it overrides a step that falls in the same cycle.
- R9: After reset the step timer is already expired, so the first enabled cycle performs a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| env_en | input | 1 | Envelope stepping enable |
| dir_up | input | 1 | 1 = step up, 0 = step down |
| rep_en | input | 1 | Reload start value at end of range |
| start_lvl | input | LVL_W | Start value used by restart and repeat |
| step_ival | input | IVAL_W | Interval field; period = (value + 1) × STEP_BASE |
| restart | input | 1 | Restart strobe: load level and full period |
| level_o | output | LVL_W | Current envelope level |

## Verification
A restart and a timer expiry can fall in the same cycle. The restart must then win: the level takes the start value, not the stepped value, and the next step comes one full period later. The bench tracks its own model of the remaining count and raises restart exactly when that count reaches zero with the enable high. It then compares the level every cycle afterwards, which shows both the loaded value and the timing of the following step. Random stimulus also produces this collision at random, and the per-cycle comparison judges those cases the same way.

// File: rtl/env_pkg.sv
package env_pkg;
   typedef enum logic {
      ENV_DOWN = 1'b0,
      ENV_UP   = 1'b1
   } env_dir_e;

   typedef enum logic [1:0] {
      ACT_HOLD    = 2'd0,
      ACT_STEP    = 2'd1,
      ACT_WRAP    = 2'd2,
      ACT_RESTART = 2'd3
   } env_act_e;
endpackage

// File: rtl/env_period_calc.sv
module env_period_calc #(
   parameter int IVAL_W    = 3,
   parameter int STEP_BASE = 307220,
   parameter int CNT_W     = 22,
   parameter bit MULT_IMPL = 1'b0
) (
   input  logic [IVAL_W-1:0] ival,
   output logic [CNT_W-1:0]  period_m1
);
   localparam int NP_W = IVAL_W + 1;
   localparam logic [CNT_W:0] BASE_V = (CNT_W+1)'(STEP_BASE);

   logic [NP_W-1:0] nplus;
   logic [CNT_W:0]  full;
   logic [CNT_W:0]  full_m1;

   assign nplus = NP_W'(ival) + NP_W'(1);

   generate
      if (MULT_IMPL) begin : g_mult
         assign full = (CNT_W+1)'((CNT_W+1)'(nplus) * BASE_V);
      end else begin : g_shadd
         logic [CNT_W:0] part [NP_W];
         for (genvar k = 0; k < NP_W; k++) begin : g_term
            assign part[k] = nplus[k] ? (BASE_V << k) : '0;
         end
         always_comb begin
            full = '0;
            for (int k = 0; k < NP_W; k++) full = full + part[k];
         end
      end
   endgenerate

   assign full_m1   = full - (CNT_W+1)'(1);
   assign period_m1 = full_m1[CNT_W-1:0];
endmodule

// File: rtl/env_step_timer.sv
module env_step_timer #(
   parameter int CNT_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [CNT_W-1:0] period_m1,
   output logic             expire
);
   logic [CNT_W-1:0] left_q;
   logic             at_zero;

   assign at_zero = (left_q == '0);
   assign expire  = run && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (restart) begin
         left_q <= period_m1;
      end else if (run) begin
         if (at_zero) left_q <= period_m1;
         else         left_q <= left_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/env_level_stepper.sv
module env_level_stepper
   import env_pkg::*;
#(
   parameter int LVL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   input  env_dir_e         dir,
   input  logic             rep,
   input  logic [LVL_W-1:0] reload,
   output logic [LVL_W-1:0] level
);
   localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

   logic [LVL_W-1:0] lvl_q;
   logic             at_end;
   env_act_e         act;

   assign at_end = (dir == ENV_UP) ? (lvl_q == TOP) : (lvl_q == '0);

   always_comb begin
      if (restart)              act = ACT_RESTART;
      else if (!step)           act = ACT_HOLD;
      else if (!at_end)         act = ACT_STEP;
      else if (rep)             act = ACT_WRAP;
      else                      act = ACT_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= '0;
      end else begin
         unique case (act)
            ACT_RESTART, ACT_WRAP: lvl_q <= reload;
            ACT_STEP: lvl_q <= (dir == ENV_UP) ? lvl_q + LVL_W'(1)
                                               : lvl_q - LVL_W'(1);
            default: lvl_q <= lvl_q;
         endcase
      end
   end

   assign level = lvl_q;
endmodule

// File: rtl/env_volume_gen.sv
module env_volume_gen
   import env_pkg::*;
#(
   parameter int LVL_W     = 4,
   parameter int IVAL_W    = 3,
   parameter int STEP_BASE = 307220,
   parameter bit MULT_IMPL = 1'b0,
   localparam int CNT_W    = ($clog2((2**IVAL_W) * STEP_BASE) < 1) ? 1
                             : $clog2((2**IVAL_W) * STEP_BASE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              env_en,
   input  logic              dir_up,
   input  logic              rep_en,
   input  logic [LVL_W-1:0]  start_lvl,
   input  logic [IVAL_W-1:0] step_ival,
   input  logic              restart,
   output logic [LVL_W-1:0]  level_o
);
   generate
      if (LVL_W < 1) begin : g_bad_lvl
         $error("env_volume_gen: LVL_W must be at least 1");
      end
      if (IVAL_W < 1 || IVAL_W > 16) begin : g_bad_ival
         $error("env_volume_gen: IVAL_W must lie in 1..16");
      end
      if (STEP_BASE < 1) begin : g_bad_base
         $error("env_volume_gen: STEP_BASE must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] period_m1;
   logic             step_fire;
   env_dir_e         dir_sel;

   assign dir_sel = dir_up ? ENV_UP : ENV_DOWN;

   env_period_calc #(
      .IVAL_W   (IVAL_W),
      .STEP_BASE(STEP_BASE),
      .CNT_W    (CNT_W),
      .MULT_IMPL(MULT_IMPL)
   ) u_period (
      .ival     (step_ival),
      .period_m1(period_m1)
   );

   env_step_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (env_en),
      .restart  (restart),
      .period_m1(period_m1),
      .expire   (step_fire)
   );

   env_level_stepper #(
      .LVL_W(LVL_W)
   ) u_level (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step_fire),
      .restart(restart),
      .dir    (dir_sel),
      .rep    (rep_en),
      .reload (start_lvl),
      .level  (level_o)
   );
endmodule

// File: rtl/env_volume_chk.sv
module env_volume_chk #(
   parameter int LVL_W     = 4,
   parameter int STEP_BASE = 307220
) (
   input logic             clk,
   input logic             rst_n,
   input logic             env_en,
   input logic             dir_up,
   input logic             rep_en,
   input logic [LVL_W-1:0] start_lvl,
   input logic             restart,
   input logic             step_fire,
   input logic [LVL_W-1:0] level_o
);
   localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

   p_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_fire && !restart && !dir_up && level_o != '0)
      |=> level_o == LVL_W'($past(level_o) - LVL_W'(1)));

   p_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_fire && !restart && dir_up && level_o != TOP)
      |=> level_o == LVL_W'($past(level_o) + LVL_W'(1)));

   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_fire && !restart && rep_en &&
       ((dir_up && level_o == TOP) || (!dir_up && level_o == '0)))
      |=> level_o == $past(start_lvl));

   p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_fire && !restart && !rep_en &&
       ((dir_up && level_o == TOP) || (!dir_up && level_o == '0)))
      |=> $stable(level_o));

   p_step_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_fire && !restart && STEP_BASE > 1) |=> !step_fire);

   p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!env_en && !restart) |=> $stable(level_o));

   p_restart_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> level_o == $past(start_lvl));

   p_restart_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && STEP_BASE > 1) |=> !step_fire);
endmodule

bind env_volume_gen env_volume_chk #(
   .LVL_W    (LVL_W),
   .STEP_BASE(STEP_BASE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .env_en   (env_en),
   .dir_up   (dir_up),
   .rep_en   (rep_en),
   .start_lvl(start_lvl),
   .restart  (restart),
   .step_fire(step_fire),
   .level_o  (level_o)
);

// File: tb/tb_env_volume_gen.sv
module tb_env_volume_gen;
   localparam int BASE = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       env_en = 1'b0;
   logic       dir_up = 1'b0;
   logic       rep_en = 1'b0;
   logic [3:0] start_lvl = '0;
   logic [2:0] step_ival = '0;
   logic       restart = 1'b0;
   logic [3:0] level_o;

   int total = 0;
   int bad = 0;
   int m_lvl = 0;
   int m_cnt = 0;

   always #5 clk = ~clk;

   env_volume_gen #(.STEP_BASE(BASE)) dut (
      .clk(clk), .rst_n(rst_n), .env_en(env_en), .dir_up(dir_up),
      .rep_en(rep_en), .start_lvl(start_lvl), .step_ival(step_ival),
      .restart(restart), .level_o(level_o)
   );

   function automatic string pick_tag();
      bit at_end;
      if (!rst_n) return "R1";
      if (restart) return "R8";
      if (!env_en) return "R7";
      if (m_cnt != 0) return "R6";
      at_end = dir_up ? (m_lvl == 15) : (m_lvl == 0);
      if (at_end) return rep_en ? "R4" : "R5";
      return dir_up ? "R3" : "R2";
   endfunction

   task automatic check(input bit ok, input string tg, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: level actual=%0d expected=%0d at %0t", tg, act, exp, $time);
      end
   endtask

   task automatic cyc();
      string tg;
      int per;
      @(posedge clk);
      tg = pick_tag();
      per = (int'(step_ival) + 1) * BASE;
      if (!rst_n) begin
         m_lvl = 0; m_cnt = 0;
      end else if (restart) begin
         m_lvl = int'(start_lvl); m_cnt = per - 1;
      end else if (env_en) begin
         if (m_cnt == 0) begin
            if (!dir_up && m_lvl != 0)       m_lvl--;
            else if (dir_up && m_lvl != 15)  m_lvl++;
            else if (rep_en)                 m_lvl = int'(start_lvl);
            m_cnt = per - 1;
         end else begin
            m_cnt--;
         end
      end
      #2;
      check(int'(level_o) == m_lvl, tg, int'(level_o), m_lvl);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   initial begin
      #2_000_000;
      total++; bad++;
      $display("FAIL R1: watchdog expired, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      run(3);
      rst_n = 1'b1;
      check(level_o == 4'd0, "R1", int'(level_o), 0);

      // R9: timer starts expired, first enabled cycle steps up
      env_en = 1'b1; dir_up = 1'b1; step_ival = 3'd1;
      cyc();
      check(level_o == 4'd1, "R9", int'(level_o), 1);

      // R3 / R5: climb into the top and hold there
      run(120);
      check(level_o == 4'd15, "R5", int'(level_o), 15);

      // R4: repeat at the top reloads start value
      start_lvl = 4'd12; rep_en = 1'b1;
      run(40);

      // R2 / R4: go down with repeat, then down to zero and hold (R5)
      dir_up = 1'b0; start_lvl = 4'd3;
      restart = 1'b1; cyc(); restart = 1'b0;
      check(level_o == 4'd3, "R8", int'(level_o), 3);
      run(60);
      rep_en = 1'b0;
      run(60);
      check(level_o == 4'd0, "R5", int'(level_o), 0);

      // R7: freeze midway through a period, then resume
      dir_up = 1'b1; step_ival = 3'd4;
      run(7);
      env_en = 1'b0;
      run(25);
      env_en = 1'b1;
      run(30);

      // R8: restart while disabled
      env_en = 1'b0; start_lvl = 4'd9;
      restart = 1'b1; cyc(); restart = 1'b0;
      check(level_o == 4'd9, "R8", int'(level_o), 9);
      run(5);

      // R8: restart landing on the same cycle as a step
      env_en = 1'b1; start_lvl = 4'd6; step_ival = 3'd2;
      for (int guard = 0; guard < 100 && m_cnt != 0; guard++) cyc();
      restart = 1'b1; cyc(); restart = 1'b0;
      check(level_o == 4'd6, "R8", int'(level_o), 6);
      run(3 * BASE + 2);

      // Random phase (R2..R8)
      for (int i = 0; i < 5000; i++) begin
         env_en  = ($urandom_range(0, 9) < 8);
         restart = ($urandom_range(0, 99) < 3);
         if ($urandom_range(0, 49) == 0) dir_up = ~dir_up;
         if ($urandom_range(0, 49) == 0) rep_en = ~rep_en;
         if ($urandom_range(0, 29) == 0) step_ival = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 19) == 0) start_lvl = 4'($urandom_range(0, 15));
         cyc();
      end
      restart = 1'b0;

      // R1: reset mid-run returns level to zero
      rst_n = 1'b0; cyc(); rst_n = 1'b1;
      check(level_o == 4'd0, "R1", int'(level_o), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule